// File: doc/BRIEF.md
# SPI Master Byte Shift Port

This block is a byte-wide SPI master meant to sit behind a small register-mapped host interface. The host sets a clock divisor and a bit-order choice, then writes a byte to the data register. That write starts a full-duplex exchange. One active-low select frames the byte, and eight serial clock periods move eight bits out on MOSI while eight bits come in from MISO.

A single shift register serves both as the data register and as the transmit/receive shifter. Each outgoing bit leaves one end of the register while each incoming bit enters the other end. After the eighth bit, the register holds the received byte and a completion flag is raised. The host reads the data register to collect the byte, and that read clears the flags.

The serial timing is fixed to one mode. The clock idles low. MISO is sampled on the rising clock edge, and MOSI moves on the falling clock edge.

Top module: `spi_shift_port`

## Requirements
- R1: The register map is: address 0 is data, address 1 is control (bit 0 = LSB-first), address 2 is the clock divisor, and address 3 is status (bit 0 = transfer done, bit 1 = write collision). `reg_rdata` always shows the addressed register. After reset the pins are `spi_ss_n`=1 and `spi_sclk`=0, control reads 0, the divisor reads `DEFAULT_DIV` (3), and status reads 0.
- R2: A write to address 0 while idle starts a transfer. `spi_ss_n` is low from the cycle after the write and stays low for exactly 16*(divisor+1) cycles, then returns high.
- R3: `spi_sclk` is low whenever `spi_ss_n` is high. During a transfer it starts low and toggles every divisor+1 cycles, which gives exactly 8 rising edges per byte.
- R4: With control bit 0 clear, the written byte leaves on MOSI starting from bit 7. MOSI is valid when select falls and changes only on falling `spi_sclk` edges.
- R5: With control bit 0 set at the start of a transfer, the byte leaves starting from bit 0.
- R6: MISO is sampled on each rising `spi_sclk` edge. At the end of the transfer, address 0 holds the received byte: in MSB-first mode the first bit received lands in bit 7, and in LSB-first mode it lands in bit 0.
- R7: The done bit is set in the same cycle that `spi_ss_n` returns high. It stays set until a read of address 0, which clears it in the following cycle.
- R8: A write to address 0 during a transfer is ignored: the outgoing stream and the received byte are unchanged. The write sets the collision bit, and a read of address 0 clears that bit.
- R9: Any divisor value, including 0, is accepted. The half-period of `spi_sclk` is always divisor+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of data clears flags) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Active-low slave select |

## Verification
All results are due at fixed cycle counts relative to the write that starts a transfer. Select falls one cycle after the write. Counting from that write, the k-th clock edge falls due at k*(divisor+1) cycles. MOSI bit j is due at 2j*(divisor+1), and select rises together with the done bit at 16*(divisor+1). Status flags clear one cycle after the read of the data register. The bench keeps a behavioural model that counts cycles from the starting write and derives these instants. It updates the model at each rising edge and compares select, clock, MOSI and status half a cycle later. All stimulus is driven 1 ns after the rising edge, so no comparison falls on an edge.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_DIV  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic collide;
        logic done;
    } port_status_t;

    // Bit that goes out first for the chosen order.
    function automatic logic out_bit(input logic [DATA_W-1:0] v, input logic lsb_first);
        return lsb_first ? v[0] : v[DATA_W-1];
    endfunction

    // One shift step: the sent bit leaves, the received bit enters at the far end.
    function automatic logic [DATA_W-1:0] shift_step(input logic [DATA_W-1:0] v,
                                                      input logic lsb_first,
                                                      input logic in_bit);
        return lsb_first ? {in_bit, v[DATA_W-1:1]} : {v[DATA_W-2:0], in_bit};
    endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q >= divisor);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: between ticks the half-period counter advances by one each cycle
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(tick)) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] load_val,
    input  logic              lsb_sel,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              ss_n,
    output logic              mosi,
    output logic              busy,
    output logic              done_pulse,
    output logic [DATA_W-1:0] shreg
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  bit_q;
    logic              sclk_q;
    logic              busy_q;
    logic              lsb_q;
    logic              sample_q;

    assign done_pulse = busy_q && tick && sclk_q && (bit_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '0;
            bit_q    <= '0;
            sclk_q   <= 1'b0;
            busy_q   <= 1'b0;
            lsb_q    <= 1'b0;
            sample_q <= 1'b0;
        end else if (start) begin
            shreg_q <= load_val;
            busy_q  <= 1'b1;
            lsb_q   <= lsb_sel;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
        end else if (busy_q && tick) begin
            if (!sclk_q) begin
                sclk_q   <= 1'b1;
                sample_q <= miso;
            end else begin
                sclk_q  <= 1'b0;
                shreg_q <= shift_step(shreg_q, lsb_q, sample_q);
                bit_q   <= bit_q + 1'b1;
                if (bit_q == LAST_BIT) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign sclk  = sclk_q;
    assign ss_n  = !busy_q;
    assign busy  = busy_q;
    assign shreg = shreg_q;
    assign mosi  = out_bit(shreg_q, lsb_q);

    // R3: clock rests low outside a frame
    a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
        ss_n |-> !sclk);

    // R4: inside a frame MOSI moves only with a falling clock
    a_r4_mosi_on_fall: assert property (@(posedge clk) disable iff (rst)
        (!ss_n && !$past(ss_n) && !$fell(sclk)) |-> $stable(mosi));

    // R2: a frame closes on the last falling clock edge
    a_r2_frame_end: assert property (@(posedge clk) disable iff (rst)
        $rose(ss_n) |-> $fell(sclk));

endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_port_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DEFAULT_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] shreg,
    input  logic              busy,
    input  logic              done_pulse,
    output logic              start,
    output logic              lsb_first,
    output logic [DIV_W-1:0]  divisor,
    output logic [DATA_W-1:0] rdata
);
    reg_sel_e     sel;
    port_status_t stat_q;
    logic         lsb_q;
    logic [DIV_W-1:0] div_q;
    logic         wr_data;
    logic         rd_data;

    assign sel     = reg_sel_e'(addr);
    assign wr_data = wr && (sel == SEL_DATA);
    assign rd_data = rd && (sel == SEL_DATA);
    assign start   = wr_data && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            lsb_q  <= 1'b0;
            div_q  <= DIV_W'(DEFAULT_DIV);
            stat_q <= '0;
        end else begin
            if (wr && sel == SEL_CTRL) lsb_q <= wdata[0];
            if (wr && sel == SEL_DIV)  div_q <= wdata[DIV_W-1:0];
            if (rd_data) begin
                stat_q.done    <= 1'b0;
                stat_q.collide <= 1'b0;
            end
            if (done_pulse)      stat_q.done    <= 1'b1;
            if (wr_data && busy) stat_q.collide <= 1'b1;
        end
    end

    always_comb begin
        case (sel)
            SEL_DATA: rdata = shreg;
            SEL_CTRL: rdata = DATA_W'(lsb_q);
            SEL_DIV:  rdata = DATA_W'(div_q);
            default:  rdata = DATA_W'(stat_q);
        endcase
    end

    assign lsb_first = lsb_q;
    assign divisor   = div_q;

    // R7: completion raises the done flag
    a_r7_done_set: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> stat_q.done);

    // R7: a data read with no completion leaves done clear
    a_r7_done_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !done_pulse) |=> !stat_q.done);

    // R8: a data write while busy flags a collision
    a_r8_collide_set: assert property (@(posedge clk) disable iff (rst)
        (wr_data && busy) |=> stat_q.collide);

endmodule

// File: rtl/spi_shift_port.sv
module spi_shift_port
    import spi_port_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DEFAULT_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_ss_n
);
    logic              start;
    logic              lsb_first;
    logic [DIV_W-1:0]  divisor;
    logic              tick;
    logic              busy;
    logic              done_pulse;
    logic [DATA_W-1:0] shreg;

    spi_reg_file #(.DIV_W(DIV_W), .DEFAULT_DIV(DEFAULT_DIV)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .shreg(shreg), .busy(busy), .done_pulse(done_pulse),
        .start(start), .lsb_first(lsb_first), .divisor(divisor), .rdata(reg_rdata)
    );

    spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .run(busy), .divisor(divisor), .tick(tick)
    );

    spi_shift_engine u_shift (
        .clk(clk), .rst(rst), .start(start), .load_val(reg_wdata),
        .lsb_sel(lsb_first), .tick(tick), .miso(spi_miso), .sclk(spi_sclk),
        .ss_n(spi_ss_n), .mosi(spi_mosi), .busy(busy), .done_pulse(done_pulse),
        .shreg(shreg)
    );

endmodule

// File: tb/tb_spi_shift_port.sv
`timescale 1ns/1ps
module tb_spi_shift_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd3;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_mosi, spi_ss_n;
    logic       spi_miso = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference state
    bit       m_active = 0;
    int       m_k = 0;
    int       m_D = 4;
    int       m_div = 3;
    bit       m_ctrl = 0;
    bit       m_lsb = 0;
    bit       m_done = 0;
    bit       m_wcol = 0;
    bit [7:0] m_tx = 0;
    bit [7:0] m_slave = 0;

    always #2.5 clk = ~clk;

    spi_shift_port dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // model update on each rising edge, from pre-edge inputs
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_active = 0; m_k = 0; m_div = 3; m_ctrl = 0; m_done = 0; m_wcol = 0;
            spi_miso <= 1'b0;
        end else begin
            bit was;
            was = m_active;
            if (reg_rd && reg_addr == 2'd0) begin m_done = 0; m_wcol = 0; end
            if (reg_wr && reg_addr == 2'd0 && was) m_wcol = 1;
            if (reg_wr && reg_addr == 2'd1) m_ctrl = reg_wdata[0];
            if (reg_wr && reg_addr == 2'd2) m_div = reg_wdata;
            if (was) begin
                m_k++;
                if (m_k == 16 * m_D) begin m_active = 0; m_done = 1; end
            end else if (reg_wr && reg_addr == 2'd0) begin
                m_active = 1; m_k = 0; m_tx = reg_wdata; m_lsb = m_ctrl; m_D = m_div + 1;
            end
            if (m_active) begin
                int j;
                j = m_k / (2 * m_D);
                spi_miso <= m_lsb ? m_slave[j] : m_slave[7-j];
            end
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // compare half a cycle after each edge
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_sclk;
            exp_sclk = m_active && (((m_k / m_D) % 2) == 1);
            chk(spi_ss_n == !m_active, "R2 ss_n frame", spi_ss_n, !m_active);
            chk(spi_sclk == exp_sclk, "R3 R9 sclk timing", spi_sclk, exp_sclk);
            if (m_active) begin
                int j;
                bit e;
                j = m_k / (2 * m_D);
                e = m_lsb ? m_tx[j] : m_tx[7-j];
                chk(spi_mosi == e, m_lsb ? "R5 mosi lsb-first" : "R4 mosi msb-first", spi_mosi, e);
            end
            if (reg_addr == 2'd3 && !reg_wr)
                chk(reg_rdata == {6'b0, m_wcol, m_done}, "R7 R8 status",
                    reg_rdata, {6'b0, m_wcol, m_done});
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, tag, reg_rdata, exp);
        @(posedge clk); #1;
        reg_rd = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (m_active) begin @(posedge clk); #1; end
        @(posedge clk); #1;
    endtask

    task automatic xfer(input logic [7:0] tx, input logic [7:0] slave);
        m_slave = slave;
        wr_reg(2'd0, tx);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(spi_ss_n == 1'b1, "R1 reset ss_n", spi_ss_n, 1);
        chk(spi_sclk == 1'b0, "R1 reset sclk", spi_sclk, 0);
        chk(reg_rdata == 8'h00, "R1 reset status", reg_rdata, 0);
        rd_check(2'd2, 8'd3, "R1 reset divisor");
        rd_check(2'd1, 8'd0, "R1 reset control");

        // R9 divisor 0, R4 msb-first, R6 receive
        wr_reg(2'd2, 8'd0);
        rd_check(2'd2, 8'd0, "R1 divisor readback");
        xfer(8'h3C, 8'hA5);
        rd_check(2'd0, 8'hA5, "R6 rx msb-first div0");

        // R5 lsb-first with divisor 2
        wr_reg(2'd2, 8'd2);
        wr_reg(2'd1, 8'd1);
        rd_check(2'd1, 8'd1, "R1 control readback");
        xfer(8'h2D, 8'h81);
        rd_check(2'd0, 8'h81, "R6 rx lsb-first");

        // R8 collision during a transfer, divisor 1, msb-first
        wr_reg(2'd1, 8'd0);
        wr_reg(2'd2, 8'd1);
        m_slave = 8'h0F;
        wr_reg(2'd0, 8'hF0);
        repeat (9) @(posedge clk);
        wr_reg(2'd0, 8'h55);
        wait_idle();
        rd_check(2'd0, 8'h0F, "R8 rx unchanged after ignored write");

        // R7 done persists over a second transfer with no read between
        xfer(8'h96, 8'h69);
        repeat (5) @(posedge clk);
        xfer(8'hC3, 8'h3C);
        rd_check(2'd0, 8'h3C, "R7 R6 second rx");

        // R5 R9 lsb-first with larger divisor, single bits at the edges
        wr_reg(2'd2, 8'd5);
        wr_reg(2'd1, 8'd1);
        xfer(8'h01, 8'h80);
        rd_check(2'd0, 8'h80, "R6 rx lsb-first div5");
        wr_reg(2'd1, 8'd0);
        xfer(8'h80, 8'h01);
        rd_check(2'd0, 8'h01, "R6 rx msb-first div5");

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule